// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Unit

This block is the arithmetic core of a Viterbi decoder step. It treats a 32-bit word as two independent signed 16-bit path-metric lanes. Its butterfly stage adds a 16-bit branch metric to one lane while subtracting it from the other, or subtracts it from both. Which lane gets which operation is chosen per request by a 2-bit opcode. The result appears one clock later with a single-cycle valid strobe. The two lanes never exchange a carry or a borrow.

A separate compare-select path takes a 32-bit word of two candidate metrics and keeps the better one. The high lane is kept only when it is strictly greater, as a signed value. The unit emits the survivor with a one-cycle strobe and records the decision. The decision bit is shifted into the bottom of a 16-bit history register and is also shown on a flag output. A decoder issues one compare-select per trellis node and reads the history register for traceback. Traceback itself and metric storage are outside this block.

Top module: `viterbi_acs_unit`

## Requirements
- R1: Opcode 2'b01 gives high lane = high + metric and low lane = low − metric, each wrapping modulo 2^16.
- R2: Opcode 2'b10 gives high lane = high − metric and low lane = low + metric, each wrapping modulo 2^16.
- R3: Opcode 2'b11 subtracts the metric from both lanes, each wrapping modulo 2^16.
- R4: The lanes are independent: a carry or borrow out of the low lane (bits 15:0) never changes the high lane (bits 31:16), and the reverse also holds.
- R5: A butterfly request with opcode 2'b00 is ignored: no result strobe follows, and the butterfly result output keeps its previous value.
- R6: The butterfly result and its strobe appear on the clock edge after an accepted request. The strobe is high for exactly one cycle per request, and the result holds between requests.
- R7: On a compare-select request where the high lane (bits 31:16) is strictly greater than the low lane (bits 15:0) as a signed value, the survivor is the high lane, 0 is shifted into history bit 0, and the flag is cleared.
- R8: On a compare-select request where the high lane is not greater (equal or smaller, signed), the survivor is the low lane, 1 is shifted into history bit 0, and the flag is set.
- R9: The history register shifts left by one and drops its MSB on each compare-select request only. Without a request, the history and the flag hold.
- R10: A synchronous active-high reset clears the history, the flag, both strobes and both data outputs.
- R11: The survivor and its strobe appear on the clock edge after a compare-select request. The strobe is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bf_req | input | 1 | Butterfly request |
| bf_op | input | 2 | Butterfly opcode (01, 10, 11 valid; 00 ignored) |
| bf_pair | input | 32 | Two path metrics, high lane in 31:16 |
| bf_metric | input | 16 | Branch metric |
| bf_done | output | 1 | Butterfly result strobe |
| bf_result | output | 32 | Butterfly result lanes |
| cs_req | input | 1 | Compare-select request |
| cs_pair | input | 32 | Candidate metrics, high lane in 31:16 |
| cs_done | output | 1 | Survivor strobe |
| cs_survivor | output | 16 | Selected survivor metric |
| cs_flag | output | 1 | Last decision (1 = low lane kept) |
| cs_history | output | 16 | Decision history, newest in bit 0 |

## Verification
A corrupted history register shows up at the `cs_history` port on the very next edge. Each decision bit then travels one position per compare-select until it leaves at the MSB, so a wrong bit stays visible for 16 requests. A wrong lane operation or a wrong sign interpretation shows up in `bf_result` or `cs_survivor` one cycle after the request. The bench predicts every output each cycle, which separates signed from unsigned compares with metrics of opposite sign, and detects cross-lane carries with values that wrap.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    BF_IDLE     = 2'b00,
    BF_HI_ADD   = 2'b01,
    BF_HI_SUB   = 2'b10,
    BF_BOTH_SUB = 2'b11
  } bf_op_e;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/acs_lane_op.sv
module acs_lane_op #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] operand,
  input  logic [LANE_W-1:0] metric,
  input  logic              subtract,
  output logic [LANE_W-1:0] result
);
  always_comb begin
    if (subtract) result = operand - metric;
    else          result = operand + metric;
  end
endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly
  import acs_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req,
  input  logic [1:0]                  op,
  input  logic [NUM_LANES*LANE_W-1:0] pair,
  input  logic [LANE_W-1:0]           metric,
  output logic                        done,
  output logic [NUM_LANES*LANE_W-1:0] result
);
  localparam int PAIR_W = NUM_LANES * LANE_W;

  logic [PAIR_W-1:0] lane_res;
  logic              accept;

  // lane i subtracts when opcode bit i is set
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    acs_lane_op #(.LANE_W(LANE_W)) u_op (
      .operand (pair[i*LANE_W +: LANE_W]),
      .metric  (metric),
      .subtract(op[i]),
      .result  (lane_res[i*LANE_W +: LANE_W])
    );
  end

  assign accept = req && (bf_op_e'(op) != BF_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= accept;
      if (accept) result <= lane_res;
    end
  end
endmodule

// File: rtl/acs_compare_select.sv
module acs_compare_select #(
  parameter int LANE_W = 16,
  parameter int TR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [2*LANE_W-1:0] pair,
  output logic              done,
  output logic [LANE_W-1:0] survivor,
  output logic              flag,
  output logic [TR_W-1:0]   history
);
  logic signed [LANE_W-1:0] hi_s, lo_s;
  logic                     keep_low;

  assign hi_s     = pair[2*LANE_W-1:LANE_W];
  assign lo_s     = pair[LANE_W-1:0];
  assign keep_low = !(hi_s > lo_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      survivor <= '0;
      flag     <= 1'b0;
      history  <= '0;
    end else begin
      done <= req;
      if (req) begin
        survivor <= keep_low ? lo_s : hi_s;
        flag     <= keep_low;
        history  <= {history[TR_W-2:0], keep_low};
      end
    end
  end
endmodule

// File: rtl/viterbi_acs_unit.sv
module viterbi_acs_unit #(
  parameter int LANE_W = 16,
  parameter int TR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bf_req,
  input  logic [1:0]          bf_op,
  input  logic [2*LANE_W-1:0] bf_pair,
  input  logic [LANE_W-1:0]   bf_metric,
  output logic                bf_done,
  output logic [2*LANE_W-1:0] bf_result,
  input  logic                cs_req,
  input  logic [2*LANE_W-1:0] cs_pair,
  output logic                cs_done,
  output logic [LANE_W-1:0]   cs_survivor,
  output logic                cs_flag,
  output logic [TR_W-1:0]     cs_history
);
  acs_butterfly #(.LANE_W(LANE_W)) u_bfly (
    .clk   (clk),
    .rst   (rst),
    .req   (bf_req),
    .op    (bf_op),
    .pair  (bf_pair),
    .metric(bf_metric),
    .done  (bf_done),
    .result(bf_result)
  );

  acs_compare_select #(.LANE_W(LANE_W), .TR_W(TR_W)) u_cs (
    .clk     (clk),
    .rst     (rst),
    .req     (cs_req),
    .pair    (cs_pair),
    .done    (cs_done),
    .survivor(cs_survivor),
    .flag    (cs_flag),
    .history (cs_history)
  );
endmodule

// File: rtl/acs_unit_checker.sv
module acs_unit_checker #(
  parameter int LANE_W = 16,
  parameter int TR_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                bf_req,
  input logic [1:0]          bf_op,
  input logic [2*LANE_W-1:0] bf_pair,
  input logic [LANE_W-1:0]   bf_metric,
  input logic                bf_done,
  input logic [2*LANE_W-1:0] bf_result,
  input logic                cs_req,
  input logic [2*LANE_W-1:0] cs_pair,
  input logic                cs_done,
  input logic [LANE_W-1:0]   cs_survivor,
  input logic                cs_flag,
  input logic [TR_W-1:0]     cs_history
);
  p_hi_add_r1: assert property (@(posedge clk) disable iff (rst)
    (bf_req && bf_op == 2'b01) |=>
      bf_result[2*LANE_W-1:LANE_W] == LANE_W'($past(bf_pair[2*LANE_W-1:LANE_W]) + $past(bf_metric)));

  p_lo_add_r2: assert property (@(posedge clk) disable iff (rst)
    (bf_req && bf_op == 2'b10) |=>
      bf_result[LANE_W-1:0] == LANE_W'($past(bf_pair[LANE_W-1:0]) + $past(bf_metric)));

  p_both_sub_r3: assert property (@(posedge clk) disable iff (rst)
    (bf_req && bf_op == 2'b11) |=>
      bf_result[LANE_W-1:0] == LANE_W'($past(bf_pair[LANE_W-1:0]) - $past(bf_metric)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(bf_req && bf_op != 2'b00) |=> (!bf_done && $stable(bf_result)));

  p_bf_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (bf_req && bf_op != 2'b00) |=> bf_done);

  p_keep_high_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_req && $signed(cs_pair[2*LANE_W-1:LANE_W]) > $signed(cs_pair[LANE_W-1:0])) |=>
      (!cs_flag && cs_survivor == $past(cs_pair[2*LANE_W-1:LANE_W])));

  p_keep_low_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_req && !($signed(cs_pair[2*LANE_W-1:LANE_W]) > $signed(cs_pair[LANE_W-1:0]))) |=>
      (cs_flag && cs_survivor == $past(cs_pair[LANE_W-1:0])));

  p_shift_r9: assert property (@(posedge clk) disable iff (rst)
    cs_req |=> (cs_history[TR_W-1:1] == $past(cs_history[TR_W-2:0]) && cs_history[0] == cs_flag));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_req |=> ($stable(cs_history) && $stable(cs_flag) && !cs_done));

  p_cs_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    cs_req |=> cs_done);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!bf_done && !cs_done && cs_history == '0 && !cs_flag));
endmodule

bind viterbi_acs_unit acs_unit_checker #(.LANE_W(LANE_W), .TR_W(TR_W)) u_chk (
  .clk(clk), .rst(rst), .bf_req(bf_req), .bf_op(bf_op), .bf_pair(bf_pair),
  .bf_metric(bf_metric), .bf_done(bf_done), .bf_result(bf_result),
  .cs_req(cs_req), .cs_pair(cs_pair), .cs_done(cs_done),
  .cs_survivor(cs_survivor), .cs_flag(cs_flag), .cs_history(cs_history)
);

// File: tb/viterbi_acs_unit_test.sv
`timescale 1ns/1ps
module viterbi_acs_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bf_req = 1'b0;
  logic [1:0]  bf_op = 2'b00;
  logic [31:0] bf_pair = '0;
  logic [15:0] bf_metric = '0;
  logic        bf_done;
  logic [31:0] bf_result;
  logic        cs_req = 1'b0;
  logic [31:0] cs_pair = '0;
  logic        cs_done;
  logic [15:0] cs_survivor;
  logic        cs_flag;
  logic [15:0] cs_history;

  int vectors = 0;
  int miscompares = 0;

  // reference state
  logic        m_bdone = 0;
  logic [31:0] m_bres = '0;
  logic        m_cdone = 0;
  logic [15:0] m_surv = '0;
  logic        m_flag = 0;
  logic [15:0] m_hist = '0;

  always #2.5 clk = ~clk;

  viterbi_acs_unit uut (
    .clk(clk), .rst(rst), .bf_req(bf_req), .bf_op(bf_op), .bf_pair(bf_pair),
    .bf_metric(bf_metric), .bf_done(bf_done), .bf_result(bf_result),
    .cs_req(cs_req), .cs_pair(cs_pair), .cs_done(cs_done),
    .cs_survivor(cs_survivor), .cs_flag(cs_flag), .cs_history(cs_history)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane(input logic [15:0] a, input logic [15:0] t, input bit sub);
    int r;
    r = sub ? (int'($signed(a)) - int'($signed(t))) : (int'($signed(a)) + int'($signed(t)));
    return 16'(r);
  endfunction

  // one clock: apply inputs, advance model, compare every output
  task automatic step(input bit r, input bit breq, input logic [1:0] op,
                      input logic [31:0] bp, input logic [15:0] bm,
                      input bit creq, input logic [31:0] cp, input string btag);
    int hi, lo;
    bit keep_low;
    rst = r; bf_req = breq; bf_op = op; bf_pair = bp; bf_metric = bm;
    cs_req = creq; cs_pair = cp;
    @(posedge clk);
    if (r) begin
      m_bdone = 0; m_bres = '0; m_cdone = 0; m_surv = '0; m_flag = 0; m_hist = '0;
    end else begin
      m_bdone = breq && (op != 2'b00);
      if (m_bdone) begin
        case (op)
          2'b01: m_bres = {lane(bp[31:16], bm, 0), lane(bp[15:0], bm, 1)};
          2'b10: m_bres = {lane(bp[31:16], bm, 1), lane(bp[15:0], bm, 0)};
          default: m_bres = {lane(bp[31:16], bm, 1), lane(bp[15:0], bm, 1)};
        endcase
      end
      m_cdone = creq;
      if (creq) begin
        hi = int'($signed(cp[31:16]));
        lo = int'($signed(cp[15:0]));
        keep_low = !(hi > lo);
        m_surv = keep_low ? cp[15:0] : cp[31:16];
        m_flag = keep_low;
        m_hist = {m_hist[14:0], keep_low};
      end
    end
    @(negedge clk);
    if (r) begin
      check("R10 bf_done", 32'(bf_done), 32'(m_bdone));
      check("R10 bf_result", bf_result, m_bres);
      check("R10 cs_history", 32'(cs_history), 32'(m_hist));
      check("R10 cs_flag/done", {30'd0, cs_flag, cs_done}, {30'd0, m_flag, m_cdone});
    end else begin
      check("R6 bf_done", 32'(bf_done), 32'(m_bdone));
      check(btag, bf_result, m_bres);
      check("R11 cs_done", 32'(cs_done), 32'(m_cdone));
      check(creq ? (m_flag ? "R8 survivor" : "R7 survivor") : "R9 survivor hold",
            32'(cs_survivor), 32'(m_surv));
      check(creq ? (m_flag ? "R8 flag" : "R7 flag") : "R9 flag hold",
            32'(cs_flag), 32'(m_flag));
      check("R9 history", 32'(cs_history), 32'(m_hist));
    end
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10: reset state
    repeat (3) step(1, 0, 2'b00, '0, '0, 0, '0, "R10");
    // R1 / R2 / R3 directed
    step(0, 1, 2'b01, 32'h0010_0020, 16'h0005, 0, '0, "R1 hi add lo sub");
    step(0, 1, 2'b10, 32'h0010_0020, 16'h0005, 0, '0, "R2 hi sub lo add");
    step(0, 1, 2'b11, 32'h0010_0020, 16'h0005, 0, '0, "R3 both sub");
    // R4: wrap in each lane without crossing
    step(0, 1, 2'b01, 32'h7FFF_0000, 16'h0001, 0, '0, "R4 lane wrap");
    step(0, 1, 2'b10, 32'h0000_FFFF, 16'h0001, 0, '0, "R4 lane wrap");
    step(0, 1, 2'b11, 32'h8000_0000, 16'h0001, 0, '0, "R4 lane borrow");
    // R5: idle opcode ignored, result holds
    step(0, 1, 2'b00, 32'h1234_5678, 16'h0101, 0, '0, "R5 idle opcode");
    step(0, 0, 2'b01, 32'hAAAA_5555, 16'h0101, 0, '0, "R5 no request");
    // R7: signed greater keeps high (5 > -5)
    step(0, 0, 2'b00, '0, '0, 1, 32'h0005_FFFB, "R6 hold");
    // R8: signed less keeps low (-1 < 1), equal keeps low
    step(0, 0, 2'b00, '0, '0, 1, 32'hFFFF_0001, "R6 hold");
    step(0, 0, 2'b00, '0, '0, 1, 32'h4000_4000, "R6 hold");
    // R9: idle holds history
    repeat (2) step(0, 0, 2'b00, '0, '0, 0, '0, "R6 hold");
    // R9: fill and overflow history
    for (int i = 0; i < 20; i++)
      step(0, 0, 2'b00, '0, '0, 1, {16'(i * 4099), 16'(i * 7919 + 3)}, "R6 hold");
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      step(0, $urandom_range(0, 1) == 1, 2'($urandom), $urandom, 16'($urandom),
           $urandom_range(0, 2) != 0, $urandom, "R1 R2 R3 random butterfly");
    // R10: reset with full history
    step(1, 1, 2'b01, 32'h1111_2222, 16'h0003, 1, 32'h0001_0002, "R10");
    step(0, 0, 2'b00, '0, '0, 0, '0, "R10 after reset");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule